// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear Commands

This block is a watchdog. A prescaler and a main counter run together from the system clock. When the combined count reaches its last value, the block gives a one-cycle time-out pulse. The surrounding chip uses that pulse as a reset while running, or as a wake-up while halted. Software must restart the count before that point by issuing clear commands. Each command arrives as a one-cycle strobe from the instruction decoder.

A static configuration input picks one of two clearing schemes:

- **Single mode:** one plain clear strobe is enough.
- **Paired mode:** two distinct commands, clear-A and clear-B, must both arrive. They may come in either order and with any gap between them, or together in the same cycle. Repeating one of them without the other does nothing.

The block also keeps two status flags for software:

- **Time-out flag:** set by an expiry.
- **Power-down flag:** set by a halt strobe.

A halt strobe also restarts the count.

Top module: `wdog_pair_clear`

## Requirements
- R1: While `rst` is high at a clock edge, `to_flag`, `pd_flag` and `timeout_pulse` become 0 and the count restarts from zero.
- R2: `timeout_pulse` goes high for exactly one cycle, 2^(PRESC_W+CNT_W) clock edges after the last restart (reset, successful clear or halt). Without any further restart it repeats with that same period.
- R3: An expiry sets `to_flag` to 1 in the same edge as the pulse and leaves `pd_flag` unchanged.
- R4: With `dual_mode`=0, a `cmd_clr` strobe restarts the count and clears both `to_flag` and `pd_flag`.
- R5: With `dual_mode`=0, `cmd_clr1` and `cmd_clr2` have no effect on the count or the flags.
- R6: With `dual_mode`=1, a successful clear occurs when a `cmd_clr2` strobe arrives after a `cmd_clr1` strobe, or the reverse, with any gap between them. It restarts the count and clears both flags. The first strobe of the pair alone changes neither.
- R7: With `dual_mode`=1, repeating `cmd_clr1` (or `cmd_clr2`) without the other strobe has no effect, and `cmd_clr` has no effect.
- R8: With `dual_mode`=1, `cmd_clr1` and `cmd_clr2` high in the same cycle form a successful clear.
- R9: After a successful paired clear the pairing memory is empty, so a later lone strobe of either kind does not clear.
- R10: A `cmd_halt` strobe restarts the count, sets `pd_flag` to 1, clears `to_flag` and empties the pairing memory.
- R11: Priority at one edge, from highest to lowest, is halt, successful clear, expiry. A halt or clear at the edge of expiry suppresses the pulse and the flag set, and a halt together with a clear leaves `pd_flag`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| dual_mode | input | 1 | 0: single-command clear, 1: paired clear (static) |
| cmd_clr | input | 1 | Single clear command strobe |
| cmd_clr1 | input | 1 | Paired clear, first kind (clear-A) |
| cmd_clr2 | input | 1 | Paired clear, second kind (clear-B) |
| cmd_halt | input | 1 | Halt command strobe |
| timeout_pulse | output | 1 | One-cycle expiry event |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |

## Verification
A wrong count or prescaler state shows as a pulse that is not exactly one period after the last restart. The bench therefore checks the cycle just before the expected expiry and the cycle of the expiry itself, so a fault shows within one period of 128 edges at the defaults. A wrong pairing memory shifts the next pulse by a large fraction of a period, because a clear is either lost or taken too early; these tests place lone strobes mid-period so the shift is unambiguous. Flag faults appear one edge after the command that should have changed them, and the bench samples the flags there.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef struct packed {
        logic clr;
        logic clr1;
        logic clr2;
        logic halt;
    } wd_cmd_t;

    typedef enum logic [1:0] {
        PAIR_NONE  = 2'd0,
        PAIR_HAVE1 = 2'd1,
        PAIR_HAVE2 = 2'd2
    } pair_st_t;

    typedef struct packed {
        logic     ok;
        pair_st_t nxt;
    } pair_res_t;

    typedef struct packed {
        logic to;
        logic pd;
    } wd_flags_t;

    // One step of the clear-command decoder.
    function automatic pair_res_t pair_step(input pair_st_t st,
                                            input logic     dual,
                                            input wd_cmd_t  c);
        pair_res_t r;
        r.ok  = 1'b0;
        r.nxt = st;
        if (!dual) begin
            r.ok  = c.clr;
            r.nxt = PAIR_NONE;
        end else if (c.clr1 && c.clr2) begin
            r.ok = 1'b1;
        end else if (c.clr1) begin
            if (st == PAIR_HAVE2) r.ok = 1'b1;
            else                  r.nxt = PAIR_HAVE1;
        end else if (c.clr2) begin
            if (st == PAIR_HAVE1) r.ok = 1'b1;
            else                  r.nxt = PAIR_HAVE2;
        end
        if (r.ok || c.halt) r.nxt = PAIR_NONE;
        return r;
    endfunction

endpackage

// File: rtl/wdog_presc.sv
module wdog_presc #(
    parameter int PRESC_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    logic [PRESC_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || restart) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    assign tick = &div_q;
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (tick)      cnt_q <= cnt_q + 1'b1;
    end

    assign expire = tick && (&cnt_q);

    // R4 / R10: a restart leaves the count far from its last value
    p_restart_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> !expire);
endmodule

// File: rtl/wdog_pair.sv
module wdog_pair
    import wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    dual_mode,
    input  wd_cmd_t cmd,
    output logic    clear_ok
);
    pair_st_t  st_q;
    pair_res_t step;

    always_comb step = pair_step(st_q, dual_mode, cmd);

    always_ff @(posedge clk) begin
        if (rst) st_q <= PAIR_NONE;
        else     st_q <= step.nxt;
    end

    assign clear_ok = step.ok;

    p_repeat_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (dual_mode && st_q == PAIR_HAVE1 && cmd.clr1 && !cmd.clr2) |-> !clear_ok);
    p_single_ignores_pair_r5: assert property (@(posedge clk) disable iff (rst)
        (!dual_mode && !cmd.clr) |-> !clear_ok);
    p_both_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (dual_mode && cmd.clr1 && cmd.clr2) |-> clear_ok);
    p_halt_empties_r10: assert property (@(posedge clk) disable iff (rst)
        cmd.halt |=> st_q == PAIR_NONE);
endmodule

// File: rtl/wdog_status.sv
module wdog_status
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      halt,
    input  logic      clear_ok,
    input  logic      expire_raw,
    output logic      timeout_pulse,
    output wd_flags_t flags
);
    logic fire;
    assign fire = expire_raw && !halt && !clear_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            timeout_pulse <= 1'b0;
            flags         <= '0;
        end else begin
            timeout_pulse <= fire;
            if (halt) begin
                flags.to <= 1'b0;
                flags.pd <= 1'b1;
            end else if (clear_ok) begin
                flags <= '0;
            end else if (fire) begin
                flags.to <= 1'b1;
            end
        end
    end

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |=> !timeout_pulse);
    p_pulse_sets_to_r3: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |-> flags.to);
    p_expire_keeps_pd_r3: assert property (@(posedge clk) disable iff (rst)
        fire |=> $stable(flags.pd));
    p_halt_flags_r10: assert property (@(posedge clk) disable iff (rst)
        halt |=> (flags.pd && !flags.to));
    p_clear_flags_r4: assert property (@(posedge clk) disable iff (rst)
        (clear_ok && !halt) |=> (!flags.pd && !flags.to));
endmodule

// File: rtl/wdog_pair_clear.sv
module wdog_pair_clear
    import wdog_pkg::*;
#(
    parameter int PRESC_W = 3,
    parameter int CNT_W   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic dual_mode,
    input  logic cmd_clr,
    input  logic cmd_clr1,
    input  logic cmd_clr2,
    input  logic cmd_halt,
    output logic timeout_pulse,
    output logic to_flag,
    output logic pd_flag
);
    localparam int TOTAL_W = PRESC_W + CNT_W;

    wd_cmd_t   cmd;
    wd_flags_t flags;
    logic      clear_ok, restart, tick, expire_raw;

    assign cmd.clr  = cmd_clr;
    assign cmd.clr1 = cmd_clr1;
    assign cmd.clr2 = cmd_clr2;
    assign cmd.halt = cmd_halt;

    wdog_pair u_pair (
        .clk      (clk),
        .rst      (rst),
        .dual_mode(dual_mode),
        .cmd      (cmd),
        .clear_ok (clear_ok)
    );

    assign restart = cmd_halt | clear_ok;

    wdog_presc #(.PRESC_W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .tick   (tick)
    );

    wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .tick   (tick),
        .expire (expire_raw)
    );

    wdog_status u_status (
        .clk          (clk),
        .rst          (rst),
        .halt         (cmd_halt),
        .clear_ok     (clear_ok),
        .expire_raw   (expire_raw),
        .timeout_pulse(timeout_pulse),
        .flags        (flags)
    );

    assign to_flag = flags.to;
    assign pd_flag = flags.pd;

    initial begin
        assert (TOTAL_W >= 2) else $error("period too short");
    end

    p_halt_over_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_halt && clear_ok) |=> (pd_flag && !timeout_pulse));
endmodule

// File: tb/tb_wdog_pair_clear.sv
module tb_wdog_pair_clear;
    localparam int PW = 3;
    localparam int CW = 4;
    localparam int P  = 2 ** (PW + CW);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dual_mode = 1'b0;
    logic cmd_clr = 1'b0, cmd_clr1 = 1'b0, cmd_clr2 = 1'b0, cmd_halt = 1'b0;
    logic timeout_pulse, to_flag, pd_flag;

    int edges = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    wdog_pair_clear #(.PRESC_W(PW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .dual_mode(dual_mode),
        .cmd_clr(cmd_clr), .cmd_clr1(cmd_clr1), .cmd_clr2(cmd_clr2),
        .cmd_halt(cmd_halt), .timeout_pulse(timeout_pulse),
        .to_flag(to_flag), .pd_flag(pd_flag)
    );

    always #2 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int t);
        while (edges < t) @(negedge clk);
    endtask

    task automatic issue(input logic c, input logic c1, input logic c2, input logic h);
        cmd_clr = c; cmd_clr1 = c1; cmd_clr2 = c2; cmd_halt = h;
        @(negedge clk);
        cmd_clr = 1'b0; cmd_clr1 = 1'b0; cmd_clr2 = 1'b0; cmd_halt = 1'b0;
    endtask

    task automatic do_reset(input logic mode);
        dual_mode = mode;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic expect_pulse_at(input int t, input string tag);
        wait_until(t - 1);
        check({tag, " no pulse before period"}, timeout_pulse, 0);
        wait_until(t);
        check({tag, " pulse at period"}, timeout_pulse, 1);
    endtask

    task automatic t_reset_expiry();
        int r;
        do_reset(1'b0);
        r = edges;
        check("R1 to_flag after reset", to_flag, 0);
        check("R1 pd_flag after reset", pd_flag, 0);
        check("R1 pulse after reset", timeout_pulse, 0);
        expect_pulse_at(r + P, "R1 R2 first expiry");
        check("R3 to_flag set by expiry", to_flag, 1);
        check("R3 pd_flag untouched by expiry", pd_flag, 0);
        idle(1);
        check("R2 pulse lasts one cycle", timeout_pulse, 0);
        expect_pulse_at(r + 2 * P, "R2 repeat");
    endtask

    task automatic t_single_clear();
        int r;
        do_reset(1'b0);
        r = edges;
        wait_until(r + P);
        idle(10);
        issue(1'b1, 1'b0, 1'b0, 1'b0);
        r = edges;
        check("R4 to_flag cleared", to_flag, 0);
        check("R4 pd_flag cleared", pd_flag, 0);
        expect_pulse_at(r + P, "R4 restart");
    endtask

    task automatic t_single_ignore();
        int r;
        do_reset(1'b0);
        r = edges;
        idle(20);
        issue(1'b0, 1'b1, 1'b0, 1'b0);
        idle(5);
        issue(1'b0, 1'b0, 1'b1, 1'b0);
        issue(1'b0, 1'b1, 1'b1, 1'b0);
        expect_pulse_at(r + P, "R5 pair strobes ignored");
        idle(3);
        issue(1'b0, 1'b1, 1'b1, 1'b0);
        check("R5 to_flag kept", to_flag, 1);
    endtask

    task automatic t_dual_pair();
        int r;
        do_reset(1'b1);
        r = edges;
        wait_until(r + P);
        idle(3);
        issue(1'b0, 1'b1, 1'b0, 1'b0);
        check("R6 half pair keeps to_flag", to_flag, 1);
        idle(7);
        issue(1'b0, 1'b0, 1'b1, 1'b0);
        r = edges;
        check("R6 pair clears to_flag", to_flag, 0);
        expect_pulse_at(r + P, "R6 A then B");
        idle(9);
        issue(1'b0, 1'b0, 1'b1, 1'b0);
        idle(4);
        issue(1'b0, 1'b1, 1'b0, 1'b0);
        r = edges;
        check("R6 reverse pair clears to_flag", to_flag, 0);
        expect_pulse_at(r + P, "R6 B then A");
    endtask

    task automatic t_dual_repeat();
        int r;
        do_reset(1'b1);
        r = edges;
        wait_until(r + P);
        issue(1'b0, 1'b1, 1'b0, 1'b0);
        issue(1'b0, 1'b1, 1'b0, 1'b0);
        issue(1'b0, 1'b1, 1'b0, 1'b0);
        issue(1'b1, 1'b0, 1'b0, 1'b0);
        check("R7 repeats keep to_flag", to_flag, 1);
        expect_pulse_at(r + 2 * P, "R7 repeats ignored");
    endtask

    task automatic t_dual_same();
        int r;
        do_reset(1'b1);
        idle(30);
        issue(1'b0, 1'b1, 1'b1, 1'b0);
        r = edges;
        expect_pulse_at(r + P, "R8 same-cycle pair");
    endtask

    task automatic t_pair_reset();
        int r;
        do_reset(1'b1);
        idle(10);
        issue(1'b0, 1'b1, 1'b0, 1'b0);
        issue(1'b0, 1'b0, 1'b1, 1'b0);
        r = edges;
        idle(20);
        issue(1'b0, 1'b0, 1'b1, 1'b0);
        expect_pulse_at(r + P, "R9 lone strobe after pair");
        idle(5);
        issue(1'b0, 1'b1, 1'b0, 1'b0);
        r = edges;
        expect_pulse_at(r + P, "R9 pairing resumes");
    endtask

    task automatic t_halt();
        int r;
        do_reset(1'b1);
        r = edges;
        wait_until(r + P);
        issue(1'b0, 1'b1, 1'b0, 1'b0);
        issue(1'b0, 1'b0, 1'b0, 1'b1);
        r = edges;
        check("R10 halt sets pd_flag", pd_flag, 1);
        check("R10 halt clears to_flag", to_flag, 0);
        idle(5);
        issue(1'b0, 1'b0, 1'b1, 1'b0);
        expect_pulse_at(r + P, "R10 halt empties pairing");
        check("R10 wake expiry sets to_flag", to_flag, 1);
        check("R3 wake expiry keeps pd_flag", pd_flag, 1);
        do_reset(1'b0);
        issue(1'b0, 1'b0, 1'b0, 1'b1);
        check("R10 halt pd_flag single mode", pd_flag, 1);
        idle(3);
        issue(1'b1, 1'b0, 1'b0, 1'b0);
        check("R4 clear drops pd_flag", pd_flag, 0);
    endtask

    task automatic t_priority();
        int r;
        do_reset(1'b0);
        r = edges;
        wait_until(r + P - 1);
        issue(1'b1, 1'b0, 1'b0, 1'b0);
        check("R11 clear suppresses pulse", timeout_pulse, 0);
        check("R11 clear suppresses to_flag", to_flag, 0);
        r = edges;
        expect_pulse_at(r + P, "R11 after clear at expiry");
        wait_until(r + 2 * P - 1);
        issue(1'b1, 1'b0, 1'b0, 1'b1);
        check("R11 halt suppresses pulse", timeout_pulse, 0);
        check("R11 halt over clear pd_flag", pd_flag, 1);
        check("R11 halt over clear to_flag", to_flag, 0);
        r = edges;
        expect_pulse_at(r + P, "R11 after halt at expiry");
    endtask

    initial begin
        t_reset_expiry();
        t_single_clear();
        t_single_ignore();
        t_dual_pair();
        t_dual_repeat();
        t_dual_same();
        t_pair_reset();
        t_halt();
        t_priority();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule